// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat in one SDRAM read or write burst. A command strobe loads a starting column, a burst-length code and an ordering type. From the following cycle the block presents one column per clock, together with a beat-valid flag. A burst-done flag marks the final beat of a burst of fixed length. The same logic can serve as the burst counter inside a memory device or as the predictor a controller uses to know which column each data beat belongs to.

Two beat orders are supported. In the sequential order the low bits of the column count upward and wrap inside the burst-sized block. In the interleaved order those same low bits are the starting column XOR the beat index. A full-page burst walks all columns of the row in the sequential order, wrapping at the end of the row, and runs until it is stopped. A burst can be cut short by a terminate strobe. A new command can also replace it on any cycle, including every cycle in a row, and no idle gap is needed between commands.

Top module: `burst_colgen`

## Requirements
- R1: While reset is high, and on the first cycle after it, beat_valid_o and done_o are 0.
- R2: When cmd_i is high at a clock edge, the following cycle shows beat_valid_o = 1 and col_o equal to the start_col_i value sampled at that edge.
- R3: With order_i = 0 (sequential) and a finite length BL, beat k keeps the column bits above log2(BL) from the start column, and its low log2(BL) bits are (start + k) mod BL.
- R4: With order_i = 1 (interleaved) and a finite length BL, beat k is the start column XOR k, for k from 0 to BL-1.
- R5: The length code bl_i is decoded as 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8 and 111 = full page. The codes 100, 101 and 110 give a burst of 1 beat.
- R6: With no cmd_i or term_i, a finite burst gives exactly BL consecutive valid beats. done_o is 1 only on the last of them, and beat_valid_o is 0 on the cycle after it.
- R7: A full-page burst steps the column by one each cycle modulo 2^COL_W (256 by default) and never raises done_o. It runs until it is terminated or replaced. A full-page code with order_i = 1 runs in the sequential order.
- R8: When term_i is high at an edge and cmd_i is not, beat_valid_o and done_o are 0 from the next cycle. The beat presented during the term_i cycle is the last one, and term_i while idle changes nothing.
- R9: cmd_i is accepted on any cycle, including during a burst, on its final beat and on consecutive cycles. Each accepted command restarts from its own column and settings on the next cycle, and it takes priority over term_i at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 1 | Read/write command strobe; starts or replaces a burst |
| start_col_i | input | COL_W | Starting column of the command |
| bl_i | input | 3 | Burst length code |
| order_i | input | 1 | Beat order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Burst terminate strobe |
| col_o | output | COL_W | Column of the current beat |
| beat_valid_o | output | 1 | Current beat is valid |
| done_o | output | 1 | Last beat of a finite burst |

## Verification
The bound checker checks the timing rules on every cycle: the first beat lands one cycle after a command and carries its column, done_o appears only with a valid beat and is followed by an idle cycle unless a new command arrives, a burst that is not yet done keeps going, and a terminate empties the pipe on the next cycle. The checker does not follow the column values themselves. The bench's scenarios show the sequential and interleaved beat orders for each length code, the reserved codes, the full-page wrap across the row end, the interleaved full-page fallback, and interruption at chosen beats.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int MAX_COL_W = 16;

    localparam logic [2:0] BLC_1    = 3'b000;
    localparam logic [2:0] BLC_2    = 3'b001;
    localparam logic [2:0] BLC_4    = 3'b010;
    localparam logic [2:0] BLC_8    = 3'b011;
    localparam logic [2:0] BLC_PAGE = 3'b111;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic [3:0] len_log2;
        logic       page;
        order_e     order;
    } burst_cfg_t;

    // Length code and order bit to burst configuration (R5, R7)
    function automatic burst_cfg_t decode_cfg(logic [2:0] code, logic ord);
        burst_cfg_t c;
        c.len_log2 = 4'd0;
        c.page     = 1'b0;
        c.order    = ord ? ORD_XOR : ORD_SEQ;
        case (code)
            BLC_2:    c.len_log2 = 4'd1;
            BLC_4:    c.len_log2 = 4'd2;
            BLC_8:    c.len_log2 = 4'd3;
            BLC_PAGE: begin
                c.page  = 1'b1;
                c.order = ORD_SEQ;
            end
            default:  c.len_log2 = 4'd0;
        endcase
        return c;
    endfunction

    // Mask of the column bits that move within a burst
    function automatic logic [MAX_COL_W-1:0] wrap_mask(burst_cfg_t c);
        logic [MAX_COL_W-1:0] one;
        one = {{(MAX_COL_W-1){1'b0}}, 1'b1};
        if (c.page) begin
            return {MAX_COL_W{1'b1}};
        end
        return (one << c.len_log2) - one;
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       bl_i,
    input  logic             order_i,
    output burst_cfg_t       cfg_o,
    output logic [COL_W-1:0] mask_o
);
    logic [MAX_COL_W-1:0] full_mask;

    always_comb begin
        cfg_o     = decode_cfg(bl_i, order_i);
        full_mask = wrap_mask(cfg_o);
        mask_o    = full_mask[COL_W-1:0];
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic [COL_W-1:0] mask_i,
    output logic             active_o,
    output logic             last_o,
    output logic [COL_W-1:0] idx_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output order_e           order_o
);
    logic             active_q;
    logic             page_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    order_e           order_q;
    logic             last_beat;

    assign last_beat = active_q && !page_q && (idx_q == mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            page_q   <= 1'b0;
            idx_q    <= '0;
            base_q   <= '0;
            mask_q   <= '0;
            order_q  <= ORD_SEQ;
        end else if (cmd_i) begin
            active_q <= 1'b1;
            page_q   <= cfg_i.page;
            idx_q    <= '0;
            base_q   <= start_col_i;
            mask_q   <= mask_i;
            order_q  <= cfg_i.order;
        end else if (term_i) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (last_beat) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign last_o   = last_beat;
    assign idx_o    = idx_q;
    assign base_o   = base_q;
    assign mask_o   = mask_q;
    assign order_o  = order_q;
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    assign sum = base_i + idx_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign seq_col[b] = mask_i[b] ? sum[b] : base_i[b];
        assign xor_col[b] = mask_i[b] ? (base_i[b] ^ idx_i[b]) : base_i[b];
    end

    assign col_o = (order_i == ORD_XOR) ? xor_col : seq_col;
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_i,
    input  logic             order_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             done_o
);
    burst_cfg_t       cfg;
    logic [COL_W-1:0] cmd_mask;
    logic             active;
    logic             last;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] run_mask;
    order_e           run_order;

    burst_cfg_decode #(.COL_W(COL_W)) u_dec (
        .bl_i    (bl_i),
        .order_i (order_i),
        .cfg_o   (cfg),
        .mask_o  (cmd_mask)
    );

    burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd_i),
        .term_i      (term_i),
        .start_col_i (start_col_i),
        .cfg_i       (cfg),
        .mask_i      (cmd_mask),
        .active_o    (active),
        .last_o      (last),
        .idx_o       (idx),
        .base_o      (base),
        .mask_o      (run_mask),
        .order_o     (run_order)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base_i  (base),
        .idx_i   (idx),
        .mask_i  (run_mask),
        .order_i (run_order),
        .col_o   (col_o)
    );

    assign beat_valid_o = active;
    assign done_o       = last;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_valid_o,
    input logic             done_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!beat_valid_o && !done_o));

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_i |=> (beat_valid_o && col_o == $past(start_col_i)));

    assert_done_in_beat_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> beat_valid_o);

    assert_done_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cmd_i) |=> !beat_valid_o);

    assert_burst_runs_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !done_o && !cmd_i && !term_i) |=> beat_valid_o);

    assert_term_stops_R8: assert property (@(posedge clk) disable iff (rst)
        (term_i && !cmd_i) |=> (!beat_valid_o && !done_o));

    assert_cmd_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i && term_i) |=> beat_valid_o);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_i        (cmd_i),
    .start_col_i  (start_col_i),
    .term_i       (term_i),
    .col_o        (col_o),
    .beat_valid_o (beat_valid_o),
    .done_o       (done_o)
);

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] bl_i = '0;
    logic       order_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_valid_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_colgen #(.COL_W(8)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .start_col_i(start_col_i),
        .bl_i(bl_i), .order_i(order_i), .term_i(term_i),
        .col_o(col_o), .beat_valid_o(beat_valid_o), .done_o(done_o)
    );

    // {expected length, length code, order, start column}
    localparam logic [15:0] VEC [0:10] = '{
        {4'd1, 3'b000, 1'b0, 8'h37},
        {4'd2, 3'b001, 1'b0, 8'h37},
        {4'd2, 3'b001, 1'b1, 8'h37},
        {4'd4, 3'b010, 1'b0, 8'h5E},
        {4'd4, 3'b010, 1'b1, 8'h5E},
        {4'd8, 3'b011, 1'b0, 8'hAD},
        {4'd8, 3'b011, 1'b1, 8'hAD},
        {4'd8, 3'b011, 1'b1, 8'hF0},
        {4'd1, 3'b100, 1'b0, 8'h10},
        {4'd1, 3'b101, 1'b1, 8'h11},
        {4'd1, 3'b110, 1'b0, 8'h12}
    };

    function automatic logic [7:0] ref_col(logic [7:0] s, int k, logic ord, int len);
        logic [7:0] m;
        logic [7:0] kk;
        m  = 8'(len - 1);
        kk = 8'(k);
        if (ord) return s ^ kk;
        return (s & ~m) | ((s + kk) & m);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after a negedge; returns when beat 0 is on the outputs
    task automatic issue(logic [2:0] code, logic ord, logic [7:0] col);
        cmd_i = 1'b1; bl_i = code; order_i = ord; start_col_i = col;
        @(negedge clk);
        cmd_i = 1'b0;
    endtask

    task automatic run_beats(string req, logic [7:0] s, logic ord, int len);
        for (int k = 0; k < len; k++) begin
            check({req, " valid"}, 32'(beat_valid_o), 32'd1);
            check({req, " col"}, 32'(col_o), 32'(ref_col(s, k, ord, len)));
            check({req, " done"}, 32'(done_o), 32'(k == len - 1));
            @(negedge clk);
        end
        check("R6 idle after burst", 32'(beat_valid_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(beat_valid_o), 32'd0);
        check("R1 reset done", 32'(done_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset valid", 32'(beat_valid_o), 32'd0);

        // Vector table: R2 R3 R4 R5 R6
        foreach (VEC[i]) begin
            issue(VEC[i][11:9], VEC[i][8], VEC[i][7:0]);
            check("R2 first col", 32'(col_o), 32'(VEC[i][7:0]));
            run_beats(VEC[i][8] ? "R4 R5" : "R3 R5", VEC[i][7:0], VEC[i][8], int'(VEC[i][15:12]));
        end

        // R7 full page wraps past the row end, no done
        issue(3'b111, 1'b0, 8'hFE);
        for (int k = 0; k < 260; k++) begin
            check("R7 page valid", 32'(beat_valid_o), 32'd1);
            check("R7 page col", 32'(col_o), 32'(8'(8'hFE + k)));
            check("R7 page done", 32'(done_o), 32'd0);
            @(negedge clk);
        end
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R8 page terminated", 32'(beat_valid_o), 32'd0);

        // R7 full page with interleave falls back to sequential
        issue(3'b111, 1'b1, 8'h13);
        check("R7 fallback col0", 32'(col_o), 32'h13);
        @(negedge clk);
        check("R7 fallback col1", 32'(col_o), 32'h14);
        @(negedge clk);
        check("R7 fallback col2", 32'(col_o), 32'h15);
        check("R7 fallback done", 32'(done_o), 32'd0);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;

        // R8 terminate mid burst
        issue(3'b011, 1'b0, 8'h20);
        @(negedge clk);
        @(negedge clk);
        term_i = 1'b1;
        check("R8 beat during term", 32'(col_o), 32'h22);
        check("R8 valid during term", 32'(beat_valid_o), 32'd1);
        @(negedge clk);
        term_i = 1'b0;
        check("R8 stopped valid", 32'(beat_valid_o), 32'd0);
        check("R8 stopped done", 32'(done_o), 32'd0);
        @(negedge clk);
        check("R8 stays stopped", 32'(beat_valid_o), 32'd0);

        // R8 terminate while idle
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R8 idle term", 32'(beat_valid_o), 32'd0);

        // R9 interrupt at beat 3 with an interleaved BL4
        issue(3'b011, 1'b0, 8'h40);
        repeat (3) @(negedge clk);
        check("R9 pre-interrupt col", 32'(col_o), 32'h43);
        issue(3'b010, 1'b1, 8'h91);
        run_beats("R9 interrupt", 8'h91, 1'b1, 4);

        // R9 back-to-back commands every cycle
        cmd_i = 1'b1; bl_i = 3'b011; order_i = 1'b0; start_col_i = 8'hA0;
        @(negedge clk);
        check("R9 b2b first", 32'(col_o), 32'hA0);
        start_col_i = 8'hB5;
        @(negedge clk);
        check("R9 b2b second", 32'(col_o), 32'hB5);
        start_col_i = 8'hC7; bl_i = 3'b000;
        @(negedge clk);
        cmd_i = 1'b0;
        check("R9 b2b third", 32'(col_o), 32'hC7);
        check("R9 b2b third done", 32'(done_o), 32'd1);
        @(negedge clk);
        check("R9 b2b idle", 32'(beat_valid_o), 32'd0);

        // R9 command beats terminate at the same edge
        term_i = 1'b1;
        issue(3'b001, 1'b0, 8'h33);
        term_i = 1'b0;
        run_beats("R9 cmd over term", 8'h33, 1'b0, 2);

        // R9 restart on the done beat
        issue(3'b001, 1'b0, 8'h50);
        @(negedge clk);
        check("R6 done before restart", 32'(done_o), 32'd1);
        issue(3'b000, 1'b0, 8'h60);
        run_beats("R9 restart on done", 8'h60, 1'b0, 1);

        // R1 reset mid burst
        issue(3'b011, 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid burst", 32'(beat_valid_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 32'(beat_valid_o), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule